// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block sits at the home node of a distributed shared-memory system. It holds the coherence record for every memory block that lives at that node, together with the block data itself. Each record holds a three-valued sharing state and a presence vector with one bit per node. Request messages from caches arrive on a single valid/ready input. The controller looks up the record and sends the needed messages on a single valid/ready output, one per cycle. These messages are invalidations, owner fetches, and the data reply to the requester. When the last message has gone, the controller writes the updated record back.

Requests are handled strictly one at a time. While the controller waits for an owner to return a dirty block, it takes no new request. The returned block comes in on a separate fill input. Invalidations are addressed only to the nodes whose presence bits are set; nothing is broadcast.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every record is Uncached with an empty presence vector, the backing data reads as zero, `req_ready` is high and `msg_valid` is low.
- R2: A read request (`req_kind` 0) to an Uncached block produces one data reply (`msg_kind` 3) to the requester, carrying the stored data and the request address. The record becomes Shared with only the requester present.
- R3: A write request (`req_kind` 1) to an Uncached block produces one data reply to the requester. The record becomes Exclusive with the requester as the only present node, the owner.
- R4: A read request to a Shared block is answered at once with a data reply from storage. The requester is added to the presence vector and the record stays Shared.
- R5: A write request to a Shared block first sends one invalidate (`msg_kind` 0) to each present node other than the requester, in ascending node order, one per handshake. It then sends the data reply. The record becomes Exclusive with the requester as owner.
- R6: A read request to an Exclusive block sends a fetch (`msg_kind` 1) to the owner and then waits for `fill_valid`. The fill data is written to storage and forwarded in the data reply. The record becomes Shared with both the old owner and the requester present.
- R7: A write request to an Exclusive block sends a fetch-and-invalidate (`msg_kind` 2) to the owner and waits for the fill. The fill data is forwarded in the data reply. The record stays Exclusive with the requester as the new owner.
- R8: A write-back (`req_kind` 2) from the owner of an Exclusive block stores `req_data` and makes the record Uncached with an empty vector. It sends no message, and `req_ready` stays high.
- R9: A write-back to a block that is not Exclusive, or from a node that is not its owner, changes neither the record nor the stored data, and sends no message.
- R10: From the acceptance of a read or write request until the handshake of its data reply, `req_ready` is low; this includes the wait for a fill. After that handshake `req_ready` is high again.
- R11: While `msg_valid` is high and `msg_ready` is low, the outgoing kind, node, address and data hold their values.
- R12: A request with `req_kind` 3 is accepted and ignored. It sends no message and leaves records unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Incoming request present |
| req_ready | output | 1 | Controller can accept a request |
| req_kind | input | 2 | 0 read, 1 write, 2 write-back, 3 unused |
| req_node | input | $clog2(NODES) | Requesting node |
| req_addr | input | $clog2(BLOCKS) | Block index |
| req_data | input | DATA_W | Write-back data |
| fill_valid | input | 1 | Owner's returned block is present |
| fill_data | input | DATA_W | Owner's returned block |
| msg_valid | output | 1 | Outgoing message present |
| msg_ready | input | 1 | Network accepts the outgoing message |
| msg_kind | output | 2 | 0 invalidate, 1 fetch, 2 fetch-and-invalidate, 3 data reply |
| msg_node | output | $clog2(NODES) | Destination node |
| msg_addr | output | $clog2(BLOCKS) | Block index of the transaction |
| msg_data | output | DATA_W | Reply data |

## Verification
The bench builds the controller with four nodes, eight blocks, 16-bit data and cleared storage. With four nodes, a write to a block shared by three nodes needs invalidations that skip the requester and still come out in ascending order. A single block can also be carried through every state, so that the following request shows which state and owner the record holds. Sixteen-bit data makes fill, write-back and stored values easy to tell apart. This is how each reply shows whether storage was updated or left alone.

// File: rtl/dir_pkg.sv
package dir_pkg;
   typedef enum logic [1:0] {
      ST_UNC = 2'd0,
      ST_SHR = 2'd1,
      ST_EXC = 2'd2
   } ent_st_e;

   localparam logic [1:0] RQ_READ  = 2'd0;
   localparam logic [1:0] RQ_WRITE = 2'd1;
   localparam logic [1:0] RQ_WBACK = 2'd2;

   localparam logic [1:0] MS_INV       = 2'd0;
   localparam logic [1:0] MS_FETCH     = 2'd1;
   localparam logic [1:0] MS_FETCH_INV = 2'd2;
   localparam logic [1:0] MS_REPLY     = 2'd3;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_INV,
      PH_FETCH,
      PH_WAIT,
      PH_REPLY
   } phase_e;
endpackage

// File: rtl/dir_pick_low.sv
module dir_pick_low #(
   parameter int NODES = 4,
   parameter int NW    = $clog2(NODES)
) (
   input  logic [NODES-1:0] mask,
   output logic [NW-1:0]    idx
);
   always_comb begin
      idx = '0;
      for (int i = NODES - 1; i >= 0; i--) begin
         if (mask[i]) idx = NW'(i);
      end
   end
endmodule

// File: rtl/dir_store.sv
module dir_store #(
   parameter int NODES     = 4,
   parameter int BLOCKS    = 8,
   parameter int DATA_W    = 32,
   parameter bit MEM_CLEAR = 1'b1,
   parameter int AW        = $clog2(BLOCKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     rd_addr,
   output logic [1:0]        rd_st,
   output logic [NODES-1:0]  rd_sh,
   output logic [DATA_W-1:0] rd_data,
   input  logic              ent_we,
   input  logic [AW-1:0]     ent_addr,
   input  logic [1:0]        ent_st,
   input  logic [NODES-1:0]  ent_sh,
   input  logic              mem_we,
   input  logic [AW-1:0]     mem_addr,
   input  logic [DATA_W-1:0] mem_wdata
);
   logic [1:0]        st_q  [BLOCKS];
   logic [NODES-1:0]  sh_q  [BLOCKS];
   logic [DATA_W-1:0] dat_q [BLOCKS];

   assign rd_st   = st_q[rd_addr];
   assign rd_sh   = sh_q[rd_addr];
   assign rd_data = dat_q[rd_addr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int b = 0; b < BLOCKS; b++) begin
            st_q[b] <= 2'd0;
            sh_q[b] <= '0;
         end
      end else if (ent_we) begin
         st_q[ent_addr] <= ent_st;
         sh_q[ent_addr] <= ent_sh;
      end
   end

   generate
      if (MEM_CLEAR) begin : g_mem_clr
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int b = 0; b < BLOCKS; b++) dat_q[b] <= '0;
            end else if (mem_we) begin
               dat_q[mem_addr] <= mem_wdata;
            end
         end
      end else begin : g_mem_raw
         always_ff @(posedge clk) begin
            if (mem_we) dat_q[mem_addr] <= mem_wdata;
         end
      end
   endgenerate
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl #(
   parameter int NODES     = 4,
   parameter int BLOCKS    = 8,
   parameter int DATA_W    = 32,
   parameter bit MEM_CLEAR = 1'b1,
   parameter int NW        = $clog2(NODES),
   parameter int AW        = $clog2(BLOCKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_kind,
   input  logic [NW-1:0]     req_node,
   input  logic [AW-1:0]     req_addr,
   input  logic [DATA_W-1:0] req_data,
   input  logic              fill_valid,
   input  logic [DATA_W-1:0] fill_data,
   output logic              msg_valid,
   input  logic              msg_ready,
   output logic [1:0]        msg_kind,
   output logic [NW-1:0]     msg_node,
   output logic [AW-1:0]     msg_addr,
   output logic [DATA_W-1:0] msg_data
);
   import dir_pkg::*;

   generate
      if (NODES < 2)  begin : g_bad_nodes  $error("NODES must be at least 2");  end
      if (BLOCKS < 2) begin : g_bad_blocks $error("BLOCKS must be at least 2"); end
      if (DATA_W < 1) begin : g_bad_width  $error("DATA_W must be positive");   end
   endgenerate

   phase_e            ph;
   logic              wr_q;
   logic [NW-1:0]     node_q;
   logic [AW-1:0]     addr_q;
   logic [NODES-1:0]  pend_q;
   logic [DATA_W-1:0] data_q;
   logic [1:0]        nst_q;
   logic [NODES-1:0]  nsh_q;
   logic [1:0]        fkind_q;

   logic [1:0]        rd_st;
   logic [NODES-1:0]  rd_sh;
   logic [DATA_W-1:0] rd_data;
   logic [NW-1:0]     pick_idx;
   logic [NODES-1:0]  req_oh;
   logic [NODES-1:0]  pick_oh;
   logic              accept, is_wr, wb_ok, fill_take, reply_done;

   assign req_oh     = NODES'(1) << req_node;
   assign pick_oh    = NODES'(1) << pick_idx;
   assign req_ready  = (ph == PH_IDLE);
   assign accept     = req_valid && req_ready &&
                       (req_kind == RQ_READ || req_kind == RQ_WRITE);
   assign is_wr      = (req_kind == RQ_WRITE);
   assign wb_ok      = req_valid && req_ready && req_kind == RQ_WBACK &&
                       rd_st == ST_EXC && rd_sh == req_oh;
   assign fill_take  = (ph == PH_WAIT) && fill_valid;
   assign reply_done = (ph == PH_REPLY) && msg_ready;

   dir_pick_low #(.NODES(NODES), .NW(NW)) u_pick (
      .mask (pend_q),
      .idx  (pick_idx)
   );

   dir_store #(
      .NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DATA_W),
      .MEM_CLEAR(MEM_CLEAR), .AW(AW)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_addr   (req_addr),
      .rd_st     (rd_st),
      .rd_sh     (rd_sh),
      .rd_data   (rd_data),
      .ent_we    (reply_done || wb_ok),
      .ent_addr  (wb_ok ? req_addr : addr_q),
      .ent_st    (wb_ok ? 2'(ST_UNC) : nst_q),
      .ent_sh    (wb_ok ? '0 : nsh_q),
      .mem_we    (wb_ok || (fill_take && !wr_q)),
      .mem_addr  (wb_ok ? req_addr : addr_q),
      .mem_wdata (wb_ok ? req_data : fill_data)
   );

   always_comb begin
      msg_valid = 1'b0;
      msg_kind  = MS_INV;
      msg_node  = pick_idx;
      unique case (ph)
         PH_INV:   begin msg_valid = 1'b1; msg_kind = MS_INV;   end
         PH_FETCH: begin msg_valid = 1'b1; msg_kind = fkind_q;  end
         PH_REPLY: begin msg_valid = 1'b1; msg_kind = MS_REPLY; msg_node = node_q; end
         default:  ;
      endcase
   end
   assign msg_addr = addr_q;
   assign msg_data = data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph      <= PH_IDLE;
         wr_q    <= 1'b0;
         node_q  <= '0;
         addr_q  <= '0;
         pend_q  <= '0;
         data_q  <= '0;
         nst_q   <= ST_UNC;
         nsh_q   <= '0;
         fkind_q <= MS_FETCH;
      end else begin
         unique case (ph)
            PH_IDLE: if (accept) begin
               wr_q   <= is_wr;
               node_q <= req_node;
               addr_q <= req_addr;
               data_q <= rd_data;
               if (rd_st == ST_EXC) begin
                  pend_q  <= rd_sh;
                  fkind_q <= is_wr ? MS_FETCH_INV : MS_FETCH;
                  nst_q   <= is_wr ? ST_EXC : ST_SHR;
                  nsh_q   <= is_wr ? req_oh : (rd_sh | req_oh);
                  ph      <= PH_FETCH;
               end else if (rd_st == ST_SHR && is_wr) begin
                  pend_q <= rd_sh & ~req_oh;
                  nst_q  <= ST_EXC;
                  nsh_q  <= req_oh;
                  ph     <= ((rd_sh & ~req_oh) != '0) ? PH_INV : PH_REPLY;
               end else if (rd_st == ST_SHR) begin
                  nst_q <= ST_SHR;
                  nsh_q <= rd_sh | req_oh;
                  ph    <= PH_REPLY;
               end else begin
                  nst_q <= is_wr ? ST_EXC : ST_SHR;
                  nsh_q <= req_oh;
                  ph    <= PH_REPLY;
               end
            end
            PH_INV: if (msg_ready) begin
               pend_q <= pend_q & ~pick_oh;
               if ((pend_q & ~pick_oh) == '0) ph <= PH_REPLY;
            end
            PH_FETCH: if (msg_ready) ph <= PH_WAIT;
            PH_WAIT: if (fill_valid) begin
               data_q <= fill_data;
               ph     <= PH_REPLY;
            end
            PH_REPLY: if (msg_ready) ph <= PH_IDLE;
            default: ph <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dir_home_chk.sv
module dir_home_chk #(
   parameter int NODES  = 4,
   parameter int BLOCKS = 8,
   parameter int DATA_W = 32,
   parameter int NW     = $clog2(NODES),
   parameter int AW     = $clog2(BLOCKS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [1:0]        req_kind,
   input logic [NW-1:0]     req_node,
   input logic              msg_valid,
   input logic              msg_ready,
   input logic [1:0]        msg_kind,
   input logic [NW-1:0]     msg_node,
   input logic [AW-1:0]     msg_addr,
   input logic [DATA_W-1:0] msg_data
);
   import dir_pkg::*;

   logic [NW-1:0] held_node;
   logic          take;

   assign take = req_valid && req_ready &&
                 (req_kind == RQ_READ || req_kind == RQ_WRITE);

   always_ff @(posedge clk) begin
      if (!rst_n) held_node <= '0;
      else if (take) held_node <= req_node;
   end

   // R1
   reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !msg_valid && req_ready);

   // R11
   msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid && !msg_ready |=> msg_valid && $stable(msg_kind) && $stable(msg_node) &&
                                  $stable(msg_addr) && $stable(msg_data));

   // R10
   busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !req_ready);

   // R10
   free_after_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid && msg_ready && msg_kind == MS_REPLY |=> req_ready && !msg_valid);

   // R5
   inv_skip_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid && msg_kind == MS_INV |-> msg_node != held_node);

   // R2
   reply_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid && msg_kind == MS_REPLY |-> msg_node == held_node);

   // R6 R7
   fetch_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid && msg_ready && (msg_kind == MS_FETCH || msg_kind == MS_FETCH_INV)
      |=> !msg_valid && !req_ready);

   // R8
   wb_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && req_kind == RQ_WBACK |=> !msg_valid && req_ready);
endmodule

bind dir_home_ctrl dir_home_chk #(
   .NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DATA_W), .NW(NW), .AW(AW)
) u_chk (.*);

// File: tb/test_dir_home_ctrl.sv
module test_dir_home_ctrl;
   localparam int NODES  = 4;
   localparam int BLOCKS = 8;
   localparam int DW     = 16;
   localparam int NW     = $clog2(NODES);
   localparam int AW     = $clog2(BLOCKS);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [1:0]    req_kind = '0;
   logic [NW-1:0] req_node = '0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_data = '0;
   logic          fill_valid = 1'b0;
   logic [DW-1:0] fill_data = '0;
   logic          msg_valid;
   logic          msg_ready = 1'b0;
   logic [1:0]    msg_kind;
   logic [NW-1:0] msg_node;
   logic [AW-1:0] msg_addr;
   logic [DW-1:0] msg_data;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   dir_home_ctrl #(.NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DW), .MEM_CLEAR(1'b1)) i_dir_home_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
      .req_node(req_node), .req_addr(req_addr), .req_data(req_data),
      .fill_valid(fill_valid), .fill_data(fill_data),
      .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
      .msg_node(msg_node), .msg_addr(msg_addr), .msg_data(msg_data)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic send(input logic [1:0] k, input int node, input int addr, input int data);
      @(negedge clk);
      for (int i = 0; i < 50 && !req_ready; i++) @(negedge clk);
      req_valid = 1'b1;
      req_kind  = k;
      req_node  = NW'(node);
      req_addr  = AW'(addr);
      req_data  = DW'(data);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // Waits for one message, compares it, then takes it after 'hold' stalled cycles.
   task automatic take(input int kind, input int node, input int addr, input int data,
                       input bit use_data, input int hold, input string tag);
      for (int i = 0; i < 20 && !msg_valid; i++) @(negedge clk);
      chk(msg_valid == 1'b1, {tag, " valid"}, int'(msg_valid), 1);
      for (int i = 0; i < hold; i++) @(negedge clk);
      chk(msg_kind == 2'(kind), {tag, " kind"}, int'(msg_kind), kind);
      chk(msg_node == NW'(node), {tag, " node"}, int'(msg_node), node);
      chk(msg_addr == AW'(addr), {tag, " addr"}, int'(msg_addr), addr);
      if (use_data) chk(msg_data == DW'(data), {tag, " data"}, int'(msg_data), data);
      msg_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      msg_ready = 1'b0;
   endtask

   task automatic fill(input int data, input string tag);
      chk(req_ready == 1'b0, {tag, " R10 busy while waiting"}, int'(req_ready), 0);
      chk(msg_valid == 1'b0, {tag, " no message while waiting"}, int'(msg_valid), 0);
      @(negedge clk);
      chk(req_ready == 1'b0, {tag, " R10 still busy"}, int'(req_ready), 0);
      fill_valid = 1'b1;
      fill_data  = DW'(data);
      @(posedge clk);
      @(negedge clk);
      fill_valid = 1'b0;
   endtask

   task automatic quiet(input string tag);
      @(negedge clk);
      chk(msg_valid == 1'b0, {tag, " no message"}, int'(msg_valid), 0);
      chk(req_ready == 1'b1, {tag, " ready"}, int'(req_ready), 1);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
      chk(msg_valid == 1'b0, "R1 no message after reset", int'(msg_valid), 0);
   endtask

   task automatic t_uncached_and_shared();
      send(2'd0, 2, 1, 0);
      take(3, 2, 1, 0, 1, 0, "R2 read uncached reply");
      quiet("R10 free after reply");
      send(2'd0, 0, 1, 0);
      take(3, 0, 1, 0, 1, 0, "R4 read shared reply");
      send(2'd1, 3, 1, 0);
      take(0, 0, 1, 0, 0, 2, "R5 first invalidate");
      take(0, 2, 1, 0, 0, 0, "R5 second invalidate");
      take(3, 3, 1, 0, 1, 3, "R5 reply after invalidates R11 hold");
   endtask

   task automatic t_writeback_and_skip();
      send(2'd2, 3, 1, 'hABCD);
      quiet("R8 write-back silent");
      send(2'd0, 1, 1, 0);
      take(3, 1, 1, 'hABCD, 1, 0, "R8 data stored and uncached");
      send(2'd0, 2, 1, 0);
      take(3, 2, 1, 'hABCD, 1, 0, "R4 second sharer");
      send(2'd1, 1, 1, 0);
      take(0, 2, 1, 0, 0, 0, "R5 invalidate skips requester");
      take(3, 1, 1, 'hABCD, 1, 0, "R5 reply to sharer-writer");
   endtask

   task automatic t_exclusive_read();
      send(2'd0, 0, 1, 0);
      take(1, 1, 1, 0, 0, 1, "R6 fetch to owner");
      fill('h1234, "R6");
      take(3, 0, 1, 'h1234, 1, 0, "R6 reply with fill data");
      send(2'd0, 3, 1, 0);
      take(3, 3, 1, 'h1234, 1, 0, "R6 memory updated and shared");
      send(2'd2, 0, 1, 'hBEEF);
      quiet("R9 write-back in shared silent");
      send(2'd0, 2, 1, 0);
      take(3, 2, 1, 'h1234, 1, 0, "R9 shared data untouched");
   endtask

   task automatic t_exclusive_write();
      send(2'd3, 0, 2, 'h1111);
      quiet("R12 unused kind ignored");
      send(2'd1, 0, 2, 0);
      take(3, 0, 2, 0, 1, 0, "R3 write uncached reply");
      send(2'd0, 1, 2, 0);
      take(1, 0, 2, 0, 0, 0, "R3 owner recorded");
      fill('h4444, "R3");
      take(3, 1, 2, 'h4444, 1, 0, "R3 follow-up reply");
      send(2'd1, 0, 3, 0);
      take(3, 0, 3, 0, 1, 0, "R3 write block 3");
      send(2'd1, 2, 3, 0);
      take(2, 0, 3, 0, 0, 0, "R7 fetch-invalidate to owner");
      fill('h5555, "R7");
      take(3, 2, 3, 'h5555, 1, 0, "R7 reply with fill data");
      send(2'd2, 0, 3, 'h9999);
      quiet("R9 write-back from old owner silent");
      send(2'd1, 1, 3, 0);
      take(2, 2, 3, 0, 0, 0, "R7 new owner tracked R9 ignored");
      fill('h6666, "R7b");
      take(3, 1, 3, 'h6666, 1, 0, "R7 second transfer");
      send(2'd2, 1, 3, 'h7777);
      quiet("R8 owner write-back silent");
      send(2'd0, 3, 3, 0);
      take(3, 3, 3, 'h7777, 1, 0, "R8 block uncached with new data");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_uncached_and_shared();
      t_writeback_and_skip();
      t_exclusive_read();
      t_exclusive_write();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule